// File: doc/BRIEF.md
# Prescaled Pseudo-Random Clock Generator

This block turns a fast system clock into a pseudo-random bit stream for spread-spectrum style excitation. A free-running counter acts as a power-of-two prescaler, or it is bypassed. The prescaler issues a one-cycle step enable, and that enable is the only thing that advances two linear feedback shift registers: an 8-bit one and a 12-bit one. The most significant bit of the selected register is the generated clock. The generated clock can be forced low, inverted, and either routed to the single pin output or replaced by an ordinary alternate output signal.

The block runs in one clock domain and never gates a clock. One 8-bit control word drives it. The divide ratio, the bypass and the sequence length are copied into an active configuration only when a step fires, so a change never cuts a division period short. The pin output is registered and follows its inputs by exactly one cycle.

Top module: `spread_clk_gen`

## Requirements
- R1: The control word `ctrl_i` is decoded as: bit 7 route, bit 6 invert, bit 5 long sequence, bit 4 enable, bit 3 bypass, bits 2:0 divide code. After reset every internal register is zero except the sequence registers, and `pin_o` is 0.
- R2: With bypass clear, a divide code d produces one step every 2^(d+1) cycles. Code 0 divides by 2 and code 7 by 256. An 8-bit counter, zero at reset, increments every cycle, and a step fires in each cycle where its low d+1 bits are all ones.
- R3: With bypass set, a step fires in every cycle.
- R4: The divide code, bypass and long-sequence bits are copied into the active configuration only in a cycle where a step fires. The active configuration is all zeros after reset.
- R5: While enable is 0, the generated bit is 0 and both sequence registers are loaded with all ones every cycle. A 0-to-1 change of enable therefore restarts both sequences from all ones.
- R6: While enabled, the 8-bit register shifts left by one on each step and takes into bit 0 the XOR of its bits 7, 5, 4 and 3. Between steps it holds. It never reaches zero.
- R7: While enabled, the 12-bit register shifts left on each step and takes into bit 0 the XOR of its bits 11, 5, 3 and 0. Between steps it holds.
- R8: The generated bit is bit 7 of the 8-bit register when the active long-sequence bit is 0, and bit 11 of the 12-bit register when it is 1.
- R9: With route set, `pin_o` carries the generated bit XOR the invert bit. When enable is 0 this makes `pin_o` equal to the invert bit.
- R10: With route clear, `pin_o` carries `alt_out_i`. In both routing cases `pin_o` is registered and shows the value selected one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the prescaler input |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Control word (route, invert, long, enable, bypass, divide) |
| alt_out_i | input | 1 | Normal-mode output passed through when route is clear |
| pin_o | output | 1 | Registered pin output |

## Verification
The assertions check on every cycle that steps never fall in two consecutive cycles without bypass, that the active configuration changes only on a step, that both sequence registers hold between steps, that they sit at all ones while disabled, and that the 8-bit register is never zero. They also check that `pin_o` follows the alternate input or the invert bit one cycle late. Only the bench's scenarios can show that each divide code gives the right period and that the tap sets give the expected bit sequences cycle by cycle. The same holds for the deferred divide and length changes and for the restart from all ones after re-enabling.

// File: rtl/spread_clk_pkg.sv
package spread_clk_pkg;

  localparam int CTRL_W = 8;
  localparam int DIV_W  = 3;
  localparam int CNT_W  = 1 << DIV_W;
  localparam int SHORT_W = 8;
  localparam int LONG_W  = 12;

  // Field order matches the decoded bit positions of the control word.
  typedef struct packed {
    logic             route;
    logic             invert;
    logic             long_seq;
    logic             enable;
    logic             bypass;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  // Configuration that only changes on a step.
  typedef struct packed {
    logic             bypass;
    logic             long_seq;
    logic [DIV_W-1:0] div;
  } act_cfg_t;

  // Low-bit mask that must be all ones for a step at divide code d.
  function automatic logic [CNT_W-1:0] period_mask(input logic [DIV_W-1:0] d);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i <= int'(d)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Feedback tap mask per register width (maximal-length polynomials).
  function automatic logic [LONG_W-1:0] tap_mask(input int width);
    logic [LONG_W-1:0] t;
    t = '0;
    if (width == SHORT_W) begin
      t[7] = 1'b1; t[5] = 1'b1; t[4] = 1'b1; t[3] = 1'b1;
    end else if (width == LONG_W) begin
      t[11] = 1'b1; t[5] = 1'b1; t[3] = 1'b1; t[0] = 1'b1;
    end
    return t;
  endfunction

  function automatic logic feedback(input logic [LONG_W-1:0] state,
                                    input logic [LONG_W-1:0] taps);
    return ^(state & taps);
  endfunction

endpackage

// File: rtl/spread_prescaler.sv
module spread_prescaler
  import spread_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ctrl_t    ctrl_i,
  output logic     step_o,
  output act_cfg_t act_o
);

  logic [CNT_W-1:0] cnt_q;
  act_cfg_t         act_q;
  logic [CNT_W-1:0] mask_w;
  logic             period_done_w;

  assign mask_w        = period_mask(act_q.div);
  assign period_done_w = ((cnt_q & mask_w) == mask_w);
  assign step_o        = act_q.bypass | period_done_w;
  assign act_o         = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Active configuration is loaded only when a step fires (R4).
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (step_o) begin
      act_q.bypass   <= ctrl_i.bypass;
      act_q.long_seq <= ctrl_i.long_seq;
      act_q.div      <= ctrl_i.div;
    end
  end

  a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !act_q.bypass) |=> (!step_o || act_q.bypass));

  a_r2_step_on_odd_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !act_q.bypass) |-> cnt_q[0]);

  a_r4_cfg_only_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |=> $stable(act_q));

endmodule

// File: rtl/spread_lfsr.sv
module spread_lfsr
  import spread_clk_pkg::*;
#(
  parameter int W = SHORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  output logic         msb_o,
  output logic [W-1:0] state_o
);

  localparam logic [LONG_W-1:0] TAPS = tap_mask(W);
  localparam logic [W-1:0]      SEED = '1;

  logic [W-1:0]      state_q;
  logic [LONG_W-1:0] wide_w;
  logic              fb_w;

  generate
    if (W < LONG_W) begin : g_pad
      assign wide_w = {{(LONG_W-W){1'b0}}, state_q};
    end else begin : g_full
      assign wide_w = state_q[LONG_W-1:0];
    end
  endgenerate

  assign fb_w    = feedback(wide_w, TAPS);
  assign msb_o   = state_q[W-1];
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else if (!en_i) begin
      state_q <= SEED;
    end else if (step_i) begin
      state_q <= {state_q[W-2:0], fb_w};
    end
  end

  a_r5_seed_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == SEED));

  a_r6_hold_between_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(state_q));

  a_r6_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

endmodule

// File: rtl/spread_out_stage.sv
module spread_out_stage
  import spread_clk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  gen_bit_i,
  input  logic  alt_i,
  output logic  pin_o
);

  logic pin_q;
  logic pin_d;

  assign pin_d = ctrl_i.route ? (gen_bit_i ^ ctrl_i.invert) : alt_i;
  assign pin_o = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  a_r10_alt_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.route |=> (pin_q == $past(alt_i)));

  a_r9_idle_shows_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.route && !ctrl_i.enable) |=> (pin_q == $past(ctrl_i.invert)));

endmodule

// File: rtl/spread_clk_gen.sv
module spread_clk_gen
  import spread_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              alt_out_i,
  output logic              pin_o
);

  ctrl_t              ctrl_w;
  act_cfg_t           act_w;
  logic               step_w;
  logic               msb_short_w;
  logic               msb_long_w;
  logic               gen_bit_w;
  logic [SHORT_W-1:0] short_state_w;
  logic [LONG_W-1:0]  long_state_w;

  assign ctrl_w = ctrl_t'(ctrl_i);

  spread_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl_w),
    .step_o (step_w),
    .act_o  (act_w)
  );

  spread_lfsr #(.W(SHORT_W)) u_seq_short (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_w.enable),
    .step_i  (step_w),
    .msb_o   (msb_short_w),
    .state_o (short_state_w)
  );

  spread_lfsr #(.W(LONG_W)) u_seq_long (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_w.enable),
    .step_i  (step_w),
    .msb_o   (msb_long_w),
    .state_o (long_state_w)
  );

  // Generated bit: forced low when disabled (R5), length chosen by active cfg (R8).
  assign gen_bit_w = ctrl_w.enable &
                     (act_w.long_seq ? msb_long_w : msb_short_w);

  spread_out_stage u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_w),
    .gen_bit_i (gen_bit_w),
    .alt_i     (alt_out_i),
    .pin_o     (pin_o)
  );

  a_r8_msb_tracks_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_short_w == short_state_w[SHORT_W-1]) && (msb_long_w == long_state_w[LONG_W-1]));

  a_r5_off_means_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_w.route && !ctrl_w.enable && !ctrl_w.invert) |=> !pin_o);

endmodule

// File: tb/spread_clk_gen_tb.sv
module spread_clk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       alt = 1'b0;
  logic       pin;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  spread_clk_gen dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ctrl_i    (ctrl),
    .alt_out_i (alt),
    .pin_o     (pin)
  );

  // Reference model written from the requirements.
  logic [7:0]  m_cnt;
  logic [2:0]  m_div;
  logic        m_byp, m_long;
  logic [7:0]  m_s8;
  logic [11:0] m_s12;
  logic        m_pin;

  function automatic logic fb8(input logic [7:0] s);
    return s[7] ^ s[5] ^ s[4] ^ s[3];
  endfunction
  function automatic logic fb12(input logic [11:0] s);
    return s[11] ^ s[5] ^ s[3] ^ s[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_byp = 0; m_long = 0;
      m_s8 = 8'hFF; m_s12 = 12'hFFF; m_pin = 0;
    end else begin
      logic stp, g;
      int   per;
      per = 2 << m_div;
      stp = m_byp || ((int'(m_cnt) % per) == per - 1);
      g   = ctrl[4] && (m_long ? m_s12[11] : m_s8[7]);
      m_pin = ctrl[7] ? (g ^ ctrl[6]) : alt;
      if (!ctrl[4]) begin
        m_s8 = 8'hFF; m_s12 = 12'hFFF;
      end else if (stp) begin
        m_s8  = {m_s8[6:0], fb8(m_s8)};
        m_s12 = {m_s12[10:0], fb12(m_s12)};
      end
      if (stp) begin
        m_div = ctrl[2:0]; m_byp = ctrl[3]; m_long = ctrl[5];
      end
      m_cnt = m_cnt + 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pin_o=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Run n cycles, comparing pin_o with the model at each falling edge.
  task automatic run_cmp(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, pin, m_pin);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctrl = 8'h00; alt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 reset pin low", pin, 1'b0);
    run_cmp("R1", 4);
  endtask

  task automatic t_alt();
    ctrl = 8'h00;
    for (int i = 0; i < 12; i++) begin
      alt = i[0] ^ i[2];
      @(negedge clk);
      check("R10 alt one-cycle delay", pin, i[0] ^ i[2]);
    end
    alt = 1'b0;
  endtask

  task automatic t_disabled();
    ctrl = 8'b1000_0000; alt = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 disabled routes zero", pin, 1'b0);
    ctrl = 8'b1100_0000;
    @(negedge clk);
    check("R9 disabled inverted is one", pin, 1'b1);
    run_cmp("R9", 6);
  endtask

  task automatic t_div_sweep();
    for (int d = 0; d < 8; d++) begin
      ctrl = {5'b1001_0, 3'(d)};
      run_cmp("R2 R6 divide sweep", 520);
    end
  endtask

  task automatic t_bypass();
    ctrl = 8'b1001_1000;
    run_cmp("R3 bypass", 40);
    ctrl = 8'b1011_1000;
    run_cmp("R7 R8 long sequence", 300);
    ctrl = 8'b1111_1000;
    run_cmp("R9 inverted long", 40);
  endtask

  task automatic t_restart();
    ctrl = 8'b1000_1000;
    @(negedge clk);
    ctrl = 8'b1001_1000;
    @(negedge clk); @(negedge clk);
    check("R5 restart from all ones", pin, 1'b1);
    run_cmp("R5 R6 after restart", 30);
  endtask

  task automatic t_cfg_change();
    ctrl = 8'b1001_0111;
    run_cmp("R4 slow divide", 300);
    ctrl = 8'b1011_0001;
    run_cmp("R4 deferred divide and length", 600);
    ctrl = 8'b1001_0000;
    run_cmp("R4 back to short", 200);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: cycle=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alt();
    t_disabled();
    t_div_sweep();
    t_bypass();
    t_restart();
    t_cfg_change();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule